// File: doc/BRIEF.md
# I2C Bus Clear Recovery Sequencer

This block frees an I2C bus whose data line is held low by a slave that lost track of a transfer. A one-cycle start pulse launches a fixed recovery run. First a not-acknowledge request goes to the bus engine, so the engine releases the data line from its side. Then the block clocks SCL nine times. Each pulse is a timed low phase followed by a timed release. Last, it asks the bus engine for a STOP condition. The block drives SCL only as an open-drain pull-down enable. It does not sense SDA and does not form the STOP waveform itself.

Phase length is set in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. A board may have no SCL line that recovery can drive. For that case the `scl_pin_en_i` input is sampled when a start is accepted. If it is low, the pulse train is left out, while the NACK and STOP requests are still issued.

The state machine has five states:
- `ST_IDLE`: waits for a start.
- `ST_NACK`: issues the NACK request for one cycle.
- `ST_LOW`: SCL is pulled down.
- `ST_HIGH`: SCL is released.
- `ST_STOP`: issues the STOP request and the done strobe for one cycle.

The transitions are:
- `ST_IDLE`→`ST_NACK` on an accepted start.
- `ST_NACK`→`ST_LOW` when the pin is enabled, and `ST_NACK`→`ST_STOP` when it is not.
- `ST_LOW`→`ST_HIGH` when the phase timer expires.
- `ST_HIGH`→`ST_LOW` when the timer expires and pulses remain.
- `ST_HIGH`→`ST_STOP` when the timer expires after the last pulse.
- `ST_STOP`→`ST_IDLE` unconditionally.

Top module: `bus_clear_seq`

## Requirements
- R1: The cycle after an accepted start, `nack_req_o` is high for exactly one cycle, and `scl_oe_o` is low in that cycle.
- R2: With the pin enabled, exactly PULSE_COUNT (default 9) rising edges of `scl_oe_o` occur between the NACK request and the STOP request. With the pin disabled, none occur.
- R3: Each pulse is a low phase (`scl_oe_o` = 1) followed by a release phase (`scl_oe_o` = 0). `scl_oe_o` is never high outside a low phase, and it is never high together with a NACK or STOP request.
- R4: Every low phase and every release phase lasts exactly PHASE_US × CYC_PER_US clock cycles (default 20 µs).
- R5: `stop_req_o` is high for exactly one cycle, in the cycle right after the last release phase ends, or right after the NACK cycle when the pin is disabled.
- R6: `busy_o` is high from the NACK cycle through the STOP cycle inclusive, and low otherwise.
- R7: `done_o` is a one-cycle strobe that coincides with `stop_req_o`.
- R8: If `scl_pin_en_i` is low when a start is accepted, the run is exactly one NACK cycle followed by one STOP cycle.
- R9: A start that arrives while `busy_o` is high, including the STOP cycle, is ignored. A start held high is accepted again only on the first idle cycle.
- R10: After reset, all outputs are low.
- R11: `scl_pin_en_i` matters only in the cycle a start is accepted. Changes to it during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery launch request, sampled on the clock edge |
| scl_pin_en_i | input | 1 | High when an SCL line is available for recovery pulses |
| scl_oe_o | output | 1 | Open-drain pull-down enable for SCL (1 = drive low) |
| nack_req_o | output | 1 | One-cycle not-acknowledge request to the bus engine |
| stop_req_o | output | 1 | One-cycle STOP condition request to the bus engine |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle strobe at the end of a run |

## Verification
A behavioural queue model builds the expected output waveform for each accepted start and is compared with all five outputs on every cycle.

The stimulus patterns and what each one tests:
- A lone start with the pin enabled checks the ordering of NACK, pulses and STOP, and the exact phase lengths.
- A start held high across the whole run separates a design that ignores starts while busy from one that re-launches. The hold also spans the STOP cycle, so the exact cycle of re-acceptance is checked.
- Runs with the pin disabled, and a run where the pin is dropped mid-sequence, show whether the pin is sampled only at acceptance.
- A separate count of SCL pull-down edges per run checks the pulse total of nine.

// File: rtl/bus_clear_pkg.sv
package bus_clear_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_NACK = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_STOP = 3'd4
    } bc_state_e;

endpackage

// File: rtl/bus_clear_phase_timer.sv
module bus_clear_phase_timer #(
    parameter int unsigned PHASE_CYC = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == LAST_VAL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bus_clear_pulse_counter.sv
module bus_clear_pulse_counter #(
    parameter int unsigned PULSE_COUNT = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic step_i,
    output logic final_o
);
    localparam int unsigned PW = (PULSE_COUNT > 1) ? $clog2(PULSE_COUNT) : 1;
    localparam logic [PW-1:0] FINAL_VAL = PW'(PULSE_COUNT - 1);

    logic [PW-1:0] done_q;

    assign final_o = (done_q == FINAL_VAL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q <= '0;
        end else if (clear_i) begin
            done_q <= '0;
        end else if (step_i) begin
            done_q <= done_q + 1'b1;
        end
    end
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq
    import bus_clear_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 250,
    parameter int unsigned PHASE_US    = 20,
    parameter int unsigned PULSE_COUNT = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic scl_pin_en_i,
    output logic scl_oe_o,
    output logic nack_req_o,
    output logic stop_req_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned PHASE_CYC = CYC_PER_US * PHASE_US;

    bc_state_e state_q, state_d;
    logic      pin_q;
    logic      phase_last;
    logic      pulse_final;
    logic      timing;
    logic      accept;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign timing = (state_q == ST_LOW) || (state_q == ST_HIGH);

    bus_clear_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (timing),
        .last_o (phase_last)
    );

    bus_clear_pulse_counter #(
        .PULSE_COUNT (PULSE_COUNT)
    ) u_pulses (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (state_q == ST_NACK),
        .step_i  ((state_q == ST_HIGH) && phase_last),
        .final_o (pulse_final)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)    state_d = ST_NACK;
            ST_NACK: state_d = pin_q ? ST_LOW : ST_STOP;
            ST_LOW:  if (phase_last) state_d = ST_HIGH;
            ST_HIGH: if (phase_last) state_d = pulse_final ? ST_STOP : ST_LOW;
            ST_STOP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and pin-enable capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) pin_q <= scl_pin_en_i;
        end
    end

    // Moore outputs
    always_comb begin
        scl_oe_o   = 1'b0;
        nack_req_o = 1'b0;
        stop_req_o = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o     = 1'b0;
            ST_NACK: nack_req_o = 1'b1;
            ST_LOW:  scl_oe_o   = 1'b1;
            ST_HIGH: ;
            ST_STOP: begin
                stop_req_o = 1'b1;
                done_o     = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_clear_seq_chk.sv
module bus_clear_seq_chk #(
    parameter int unsigned CYC_PER_US = 250,
    parameter int unsigned PHASE_US   = 20
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic scl_pin_en_i,
    input logic scl_oe_o,
    input logic nack_req_o,
    input logic stop_req_o,
    input logic busy_o,
    input logic done_o
);
    localparam int unsigned PHASE_CYC = CYC_PER_US * PHASE_US;

    int unsigned low_run;
    int unsigned high_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run  <= 0;
            high_run <= 0;
        end else begin
            low_run  <= scl_oe_o ? low_run + 1 : 0;
            high_run <= (busy_o && !scl_oe_o && !nack_req_o && !stop_req_o) ? high_run + 1 : 0;
        end
    end

    // R1
    nack_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> nack_req_o && !scl_oe_o);

    // R1
    nack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nack_req_o |=> !nack_req_o);

    // R3
    oe_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_oe_o |-> busy_o && !nack_req_o && !stop_req_o);

    // R4
    low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_oe_o) |-> low_run == PHASE_CYC);

    // R4
    high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(scl_oe_o) && !$past(nack_req_o)) || (stop_req_o && !$past(nack_req_o))
        |-> high_run == PHASE_CYC);

    // R7
    done_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o == stop_req_o);

    // R6
    stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_o |=> !busy_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && !stop_req_o |=> busy_o);

    // R8
    no_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nack_req_o && !$past(scl_pin_en_i) |=> stop_req_o);
endmodule

bind bus_clear_seq bus_clear_seq_chk #(
    .CYC_PER_US (CYC_PER_US),
    .PHASE_US   (PHASE_US)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .scl_pin_en_i (scl_pin_en_i),
    .scl_oe_o     (scl_oe_o),
    .nack_req_o   (nack_req_o),
    .stop_req_o   (stop_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/bus_clear_seq_bench.sv
module bus_clear_seq_bench;
    localparam int unsigned CYC_PER_US  = 2;
    localparam int unsigned PHASE_US    = 20;
    localparam int unsigned PULSE_COUNT = 9;
    localparam int unsigned PHASE_CYC   = CYC_PER_US * PHASE_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pin_en = 1'b1;
    logic scl_oe, nack_req, stop_req, busy, done;

    int unsigned vectors = 0;
    int unsigned errors  = 0;
    int unsigned cycles  = 0;

    always #2 clk = ~clk;

    bus_clear_seq #(
        .CYC_PER_US  (CYC_PER_US),
        .PHASE_US    (PHASE_US),
        .PULSE_COUNT (PULSE_COUNT)
    ) u_bus_clear_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .scl_pin_en_i (pin_en),
        .scl_oe_o     (scl_oe),
        .nack_req_o   (nack_req),
        .stop_req_o   (stop_req),
        .busy_o       (busy),
        .done_o       (done)
    );

    // Reference model: {scl_oe, nack, stop, busy, done}
    logic [4:0] q[$];
    logic [4:0] exp_v = 5'b0;
    logic       run_pin = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            exp_v   <= 5'b0;
            run_pin <= 1'b0;
        end else begin
            // R9: accepted only when the model shows idle (not busy)
            if (!exp_v[1] && start) begin
                run_pin <= pin_en;
                q.push_back(5'b01010);
                if (pin_en) begin
                    for (int p = 0; p < PULSE_COUNT; p++) begin
                        for (int c = 0; c < PHASE_CYC; c++) q.push_back(5'b10010);
                        for (int c = 0; c < PHASE_CYC; c++) q.push_back(5'b00010);
                    end
                end
                q.push_back(5'b00111);
            end
            if (q.size() > 0) exp_v <= q.pop_front();
            else              exp_v <= 5'b0;
        end
    end

    function automatic string req_of(input logic [4:0] diff);
        if (diff[4]) return "R3/R4";
        if (diff[3]) return "R1";
        if (diff[2]) return "R5";
        if (diff[1]) return "R6";
        return "R7";
    endfunction

    // Cycle compare, away from the active edge
    logic prev_oe = 1'b0;
    int unsigned rises = 0;
    always @(negedge clk) begin
        logic [4:0] act;
        act = {scl_oe, nack_req, stop_req, busy, done};
        vectors++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s (R10 if in reset) cycle %0d: actual %b expected %b",
                     req_of(act ^ exp_v), cycles, act, exp_v);
        end
        // R2: pulse total per run
        if (rst_n && scl_oe && !prev_oe) rises++;
        if (rst_n && stop_req) begin
            vectors++;
            if (rises != (run_pin ? PULSE_COUNT : 0)) begin
                errors++;
                $display("FAIL R2 pulse count: actual %0d expected %0d",
                         rises, run_pin ? PULSE_COUNT : 0);
            end
            rises = 0;
        end
        prev_oe = scl_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                // R10: reset state observed by the per-cycle compare
                tick(3);
                rst_n = 1'b1;
                tick(4);
                // Full run with pin, start held high (R9), pin dropped mid-run (R11)
                pin_en = 1'b1;
                start  = 1'b1;
                tick(25);
                start  = 1'b0;
                tick(100);
                pin_en = 1'b0;
                wait_idle();
                tick(3);
                // R8: pin disabled, single start
                start = 1'b1;
                tick(1);
                start = 1'b0;
                tick(6);
                // R9: start held across STOP, re-accepted on idle cycle
                start = 1'b1;
                tick(12);
                start = 1'b0;
                wait_idle();
                tick(2);
                // R2, R4, R5: another full run with pin, start held across its STOP
                pin_en = 1'b1;
                start  = 1'b1;
                tick(1);
                start  = 1'b0;
                tick(PULSE_COUNT * 2 * PHASE_CYC - 1);
                start  = 1'b1;
                tick(4);
                start  = 1'b0;
                wait_idle();
                tick(5);
            end
            begin
                while (cycles < 20000) begin
                    @(posedge clk);
                    cycles++;
                end
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule